// File: doc/BRIEF.md
# CAN Receive Acceptance and Buffer Steering

This block sits after a CAN receiver. It takes one complete frame per strobe: the identifier, the extended/standard flag, the remote flag and the first two data bytes. It decides whether the frame is kept and which of two receive slots gets it. Each slot has its own mask. Slot 0 owns filters 0 and 1, and slot 1 owns filters 2 to 5. Every filter holds a 29-bit pattern and an extended-frame flag. For standard data frames, the filter bits below the 11-bit identifier are compared against the two leading data bytes.

The host sets masks, filters, slot modes and the slot-0 overflow-to-slot-1 option through a small write port. Those writes are honoured only while the configuration input is high. Frames that arrive in that state are discarded. Once a slot is written it reports full, and it accepts nothing more until the host pulses its clear line. A frame that is accepted but has no free slot raises a one-cycle overflow pulse and is lost.

Top module: `can_accept_steer`

## Requirements
- R1: After reset the following are all zero: `store_o`, `ovf_o`, `full_o`, both stored identifiers and both stored hit numbers. All masks and filters are zero, every filter's extended flag is 0, both slot modes are 00 and overflow-to-slot-1 is off.
- R2: Slot 0 (filters 0–1, mask 0) has priority. A frame slot 0 accepts goes to slot 0 when slot 0 is empty. Otherwise the frame goes to slot 1 when slot 1 accepts it, or takes the R8 path, and slot 1 is empty. At most one `store_o` bit is ever set.
- R3: A filter hits only when its extended flag equals `frm_ide_i` and the masked key bits equal the filter bits. A mask bit of 1 forces equality and a mask bit of 0 ignores that bit.
- R4: Extended frames compare all 29 bits of `frm_id_i`. Standard frames compare bits 28:18 as the identifier. For standard data frames (`frm_rtr_i`=0), bits 17:10 are compared to data byte 0 and bits 9:2 to data byte 1. Bits 1:0 are never compared for standard frames, and standard remote frames compare only bits 28:18.
- R5: Slot mode, bits 1:0 of a mode write, selects what the slot accepts. 00 takes any frame that hits, 01 only standard frames that hit, and 10 only extended frames that hit. 11 takes every frame, with the hit number recorded as 7.
- R6: A frame is stored only into an empty slot. If it is accepted but no slot can take it, `ovf_o` pulses for one cycle and both stored identifiers stay unchanged. Store and overflow pulses, stored identifier and hit appear in the cycle after the edge that samples `frm_valid_i`.
- R7: The recorded hit number is the lowest-numbered filter of the accepting slot that hit. A frame moved to slot 1 by R8 records slot 0's filter number.
- R8: When overflow-to-slot-1 is on (bit 2 of the slot-0 mode write), a frame slot 0 accepts while slot 0 is full goes to slot 1 if slot 1 is empty.
- R9: A slot's full flag rises with its store and stays high until the matching `clr_full_i` bit is seen at a clock edge.
- R10: Writes go to address 0–5 for filters (data bit 29 is the extended flag, bits 28:0 the pattern), 6 and 7 for masks 0 and 1, and 8 and 9 for the slot 0 and slot 1 modes. Writes take effect only when `cfg_mode_i`=1, and frames presented while `cfg_mode_i`=1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode_i | input | 1 | Configuration state: enables writes, blocks frames |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration register select |
| cfg_wdata_i | input | 30 | Configuration write data |
| frm_valid_i | input | 1 | One-cycle strobe: a complete frame is presented |
| frm_ide_i | input | 1 | Frame carries a 29-bit identifier |
| frm_rtr_i | input | 1 | Frame is a remote request |
| frm_id_i | input | 29 | Identifier; standard ID in bits 28:18 |
| frm_db0_i | input | 8 | Data byte 0 |
| frm_db1_i | input | 8 | Data byte 1 |
| clr_full_i | input | 2 | Per-slot full flag clear |
| store_o | output | 2 | Per-slot write pulse |
| ovf_o | output | 1 | Accepted frame dropped, no free slot |
| full_o | output | 2 | Per-slot occupied flag |
| buf0_id_o | output | 29 | Slot 0 stored identifier |
| buf0_hit_o | output | 3 | Slot 0 filter hit number |
| buf1_id_o | output | 29 | Slot 1 stored identifier |
| buf1_hit_o | output | 3 | Slot 1 filter hit number |

## Verification
The bound assertions watch several control rules on every cycle. They check that no store lands in a slot that was full, that full flags stay up until cleared and drop on a clear, and that at most one slot is written per frame. They also check that overflow never coincides with a store, that nothing is stored or dropped in the cycle after configuration state, and that slot 1 only records a slot-0 filter when slot 0 was full. Which frame passes which filter cannot be seen by a property. The bench's scenarios and its behavioural model show the bit-level comparison, the data-byte and remote-frame handling, each mode code, lowest-filter priority and the gating of writes outside configuration state.

// File: rtl/cafs_pkg.sv
package cafs_pkg;

   typedef enum logic [1:0] {
      RXM_ANY = 2'b00,
      RXM_STD = 2'b01,
      RXM_EXT = 2'b10,
      RXM_OFF = 2'b11
   } rxm_e;

   // Slot-level admission given mode, frame type and whether any owned filter hit.
   function automatic logic mode_admits(input rxm_e m, input logic ide, input logic any_hit);
      case (m)
         RXM_ANY: return any_hit;
         RXM_STD: return any_hit & ~ide;
         RXM_EXT: return any_hit & ide;
         default: return 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/cafs_cfg.sv
module cafs_cfg #(
   parameter int ID_W     = 29,
   parameter int NUM_FILT = 6,
   parameter int AW       = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_mode_i,
   input  logic                          cfg_we_i,
   input  logic [AW-1:0]                 cfg_addr_i,
   input  logic [ID_W:0]                 cfg_wdata_i,
   output logic [NUM_FILT-1:0][ID_W-1:0] filt_o,
   output logic [NUM_FILT-1:0]           fext_o,
   output logic [1:0][ID_W-1:0]          mask_o,
   output logic [1:0][1:0]               mode_o,
   output logic                          roll_o
);
   localparam int MASK_BASE = NUM_FILT;
   localparam int MODE_BASE = NUM_FILT + 2;

   logic wr_ok;
   assign wr_ok = cfg_mode_i & cfg_we_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_o <= '0;
         fext_o <= '0;
         mask_o <= '0;
         mode_o <= '0;
         roll_o <= 1'b0;
      end else if (wr_ok) begin
         for (int f = 0; f < NUM_FILT; f++) begin
            if (cfg_addr_i == AW'(f)) begin
               filt_o[f] <= cfg_wdata_i[ID_W-1:0];
               fext_o[f] <= cfg_wdata_i[ID_W];
            end
         end
         for (int m = 0; m < 2; m++) begin
            if (cfg_addr_i == AW'(MASK_BASE + m))
               mask_o[m] <= cfg_wdata_i[ID_W-1:0];
            if (cfg_addr_i == AW'(MODE_BASE + m))
               mode_o[m] <= cfg_wdata_i[1:0];
         end
         if (cfg_addr_i == AW'(MODE_BASE))
            roll_o <= cfg_wdata_i[2];
      end
   end

endmodule

// File: rtl/cafs_match.sv
module cafs_match #(
   parameter int ID_W = 29
) (
   input  logic [ID_W-1:0] key_i,
   input  logic [ID_W-1:0] care_i,
   input  logic [ID_W-1:0] filt_i,
   input  logic [ID_W-1:0] mask_i,
   input  logic            ide_i,
   input  logic            fext_i,
   output logic            hit_o
);
   logic [ID_W-1:0] diff;
   assign diff  = (key_i ^ filt_i) & mask_i & care_i;
   assign hit_o = (fext_i == ide_i) && (diff == '0);
endmodule

// File: rtl/cafs_steer.sv
module cafs_steer
   import cafs_pkg::*;
#(
   parameter int ID_W      = 29,
   parameter int NUM_FILT  = 6,
   parameter int NUM_FILT0 = 2,
   parameter int HIT_W     = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       frm_go_i,
   input  logic                       frm_ide_i,
   input  logic [ID_W-1:0]            frm_id_i,
   input  logic [NUM_FILT-1:0]        hit_i,
   input  logic [1:0][1:0]            mode_i,
   input  logic                       roll_i,
   input  logic [1:0]                 clr_full_i,
   output logic [1:0]                 store_o,
   output logic                       ovf_o,
   output logic [1:0]                 full_o,
   output logic [1:0][ID_W-1:0]       id_o,
   output logic [1:0][HIT_W-1:0]      hit_o
);
   localparam logic [HIT_W-1:0] HIT_NONE = '1;

   logic [1:0][HIT_W-1:0] idx;
   logic [1:0]            any_hit, acc, go;
   logic                  roll_path, ovf_d;
   logic [HIT_W-1:0]      rec1;

   always_comb begin
      idx     = '1;
      any_hit = '0;
      for (int f = NUM_FILT0 - 1; f >= 0; f--) begin
         if (hit_i[f]) begin
            idx[0]     = HIT_W'(f);
            any_hit[0] = 1'b1;
         end
      end
      for (int f = NUM_FILT - 1; f >= NUM_FILT0; f--) begin
         if (hit_i[f]) begin
            idx[1]     = HIT_W'(f);
            any_hit[1] = 1'b1;
         end
      end
      for (int b = 0; b < 2; b++) begin
         acc[b] = mode_admits(rxm_e'(mode_i[b]), frm_ide_i, any_hit[b]);
         if (rxm_e'(mode_i[b]) == RXM_OFF) idx[b] = HIT_NONE;
      end
   end

   assign go[0]     = frm_go_i & acc[0] & ~full_o[0];
   assign roll_path = frm_go_i & acc[0] & full_o[0] & roll_i;
   assign go[1]     = frm_go_i & ~go[0] & (acc[1] | roll_path) & ~full_o[1];
   assign rec1      = roll_path ? idx[0] : idx[1];
   assign ovf_d     = frm_go_i & (|acc) & ~(|go);

   for (genvar b = 0; b < 2; b++) begin : g_slot
      logic             full_q;
      logic [ID_W-1:0]  id_q;
      logic [HIT_W-1:0] hit_q;
      logic [HIT_W-1:0] rec;

      if (b == 0) begin : g_rec_own
         assign rec = idx[0];
      end else begin : g_rec_roll
         assign rec = rec1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            full_q <= 1'b0;
            id_q   <= '0;
            hit_q  <= '0;
         end else begin
            full_q <= (full_q & ~clr_full_i[b]) | go[b];
            if (go[b]) begin
               id_q  <= frm_id_i;
               hit_q <= rec;
            end
         end
      end

      assign full_o[b] = full_q;
      assign id_o[b]   = id_q;
      assign hit_o[b]  = hit_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_o <= '0;
         ovf_o   <= 1'b0;
      end else begin
         store_o <= go;
         ovf_o   <= ovf_d;
      end
   end

endmodule

// File: rtl/can_accept_steer.sv
module can_accept_steer #(
   parameter int ID_W      = 29,
   parameter int STD_W     = 11,
   parameter int BYTE_W    = 8,
   parameter int NUM_FILT  = 6,
   parameter int NUM_FILT0 = 2,
   parameter int AW        = $clog2(NUM_FILT + 4),
   parameter int HIT_W     = $clog2(NUM_FILT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_mode_i,
   input  logic              cfg_we_i,
   input  logic [AW-1:0]     cfg_addr_i,
   input  logic [ID_W:0]     cfg_wdata_i,
   input  logic              frm_valid_i,
   input  logic              frm_ide_i,
   input  logic              frm_rtr_i,
   input  logic [ID_W-1:0]   frm_id_i,
   input  logic [BYTE_W-1:0] frm_db0_i,
   input  logic [BYTE_W-1:0] frm_db1_i,
   input  logic [1:0]        clr_full_i,
   output logic [1:0]        store_o,
   output logic              ovf_o,
   output logic [1:0]        full_o,
   output logic [ID_W-1:0]   buf0_id_o,
   output logic [HIT_W-1:0]  buf0_hit_o,
   output logic [ID_W-1:0]   buf1_id_o,
   output logic [HIT_W-1:0]  buf1_hit_o
);
   localparam int EXT_W = ID_W - STD_W;
   localparam int DB_W  = 2 * BYTE_W;

   if (EXT_W < DB_W) begin : g_bad_width
      $error("identifier extension narrower than two data bytes");
   end
   if (NUM_FILT0 < 1 || NUM_FILT0 >= NUM_FILT) begin : g_bad_split
      $error("each slot needs at least one filter");
   end
   if ((1 << HIT_W) - 1 < NUM_FILT) begin : g_bad_hitw
      $error("hit field cannot encode all filters plus the none code");
   end
   if ((1 << AW) < NUM_FILT + 4) begin : g_bad_aw
      $error("configuration address too narrow");
   end

   logic [NUM_FILT-1:0][ID_W-1:0] filt;
   logic [NUM_FILT-1:0]           fext;
   logic [1:0][ID_W-1:0]          mask;
   logic [1:0][1:0]               mode;
   logic                          roll;
   logic [ID_W-1:0]               key, care;
   logic [NUM_FILT-1:0]           hit;
   logic [1:0][ID_W-1:0]          slot_id;
   logic [1:0][HIT_W-1:0]         slot_hit;
   logic                          frm_go;

   cafs_cfg #(.ID_W(ID_W), .NUM_FILT(NUM_FILT), .AW(AW)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_mode_i (cfg_mode_i),
      .cfg_we_i   (cfg_we_i),
      .cfg_addr_i (cfg_addr_i),
      .cfg_wdata_i(cfg_wdata_i),
      .filt_o     (filt),
      .fext_o     (fext),
      .mask_o     (mask),
      .mode_o     (mode),
      .roll_o     (roll)
   );

   // Comparison key and care vector: standard frames reuse the extension field for data bytes.
   always_comb begin
      key  = frm_id_i;
      care = '1;
      if (!frm_ide_i) begin
         key[EXT_W-1 -: DB_W] = {frm_db0_i, frm_db1_i};
         care[EXT_W-1:0]      = '0;
         if (!frm_rtr_i) care[EXT_W-1 -: DB_W] = '1;
      end
   end

   for (genvar f = 0; f < NUM_FILT; f++) begin : g_cmp
      localparam int MSEL = (f < NUM_FILT0) ? 0 : 1;
      cafs_match #(.ID_W(ID_W)) u_match (
         .key_i (key),
         .care_i(care),
         .filt_i(filt[f]),
         .mask_i(mask[MSEL]),
         .ide_i (frm_ide_i),
         .fext_i(fext[f]),
         .hit_o (hit[f])
      );
   end

   assign frm_go = frm_valid_i & ~cfg_mode_i;

   cafs_steer #(
      .ID_W(ID_W), .NUM_FILT(NUM_FILT), .NUM_FILT0(NUM_FILT0), .HIT_W(HIT_W)
   ) u_steer (
      .clk       (clk),
      .rst_n     (rst_n),
      .frm_go_i  (frm_go),
      .frm_ide_i (frm_ide_i),
      .frm_id_i  (frm_id_i),
      .hit_i     (hit),
      .mode_i    (mode),
      .roll_i    (roll),
      .clr_full_i(clr_full_i),
      .store_o   (store_o),
      .ovf_o     (ovf_o),
      .full_o    (full_o),
      .id_o      (slot_id),
      .hit_o     (slot_hit)
   );

   assign buf0_id_o  = slot_id[0];
   assign buf1_id_o  = slot_id[1];
   assign buf0_hit_o = slot_hit[0];
   assign buf1_hit_o = slot_hit[1];

endmodule

// File: rtl/cafs_chk.sv
module cafs_chk #(
   parameter int NUM_FILT0 = 2,
   parameter int HIT_W     = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_mode_i,
   input logic [1:0]       clr_full_i,
   input logic [1:0]       store_o,
   input logic             ovf_o,
   input logic [1:0]       full_o,
   input logic [HIT_W-1:0] buf0_hit_o,
   input logic [HIT_W-1:0] buf1_hit_o
);
   localparam logic [HIT_W-1:0] NONE = '1;
   localparam logic [HIT_W-1:0] F0N  = HIT_W'(NUM_FILT0);

   a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(store_o));

   a_r6_store0_into_empty: assert property (@(posedge clk) disable iff (!rst_n)
      store_o[0] |-> !$past(full_o[0]));

   a_r6_store1_into_empty: assert property (@(posedge clk) disable iff (!rst_n)
      store_o[1] |-> !$past(full_o[1]));

   a_r6_ovf_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> (store_o == 2'b00));

   a_r9_hold0: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o[0] && !clr_full_i[0]) |=> full_o[0]);

   a_r9_hold1: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o[1] && !clr_full_i[1]) |=> full_o[1]);

   a_r9_clear0: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o[0] && clr_full_i[0]) |=> !full_o[0]);

   a_r9_clear1: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o[1] && clr_full_i[1]) |=> !full_o[1]);

   a_r9_store_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
      (store_o != 2'b00) |-> ((store_o & full_o) == store_o));

   a_r10_cfg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_mode_i |=> (store_o == 2'b00 && !ovf_o));

   a_r7_hit0_range: assert property (@(posedge clk) disable iff (!rst_n)
      store_o[0] |-> (buf0_hit_o < F0N || buf0_hit_o == NONE));

   a_r8_roll_needs_full0: assert property (@(posedge clk) disable iff (!rst_n)
      (store_o[1] && buf1_hit_o < F0N) |-> $past(full_o[0]));

endmodule

bind can_accept_steer cafs_chk #(.NUM_FILT0(NUM_FILT0), .HIT_W(HIT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_mode_i (cfg_mode_i),
   .clr_full_i (clr_full_i),
   .store_o    (store_o),
   .ovf_o      (ovf_o),
   .full_o     (full_o),
   .buf0_hit_o (buf0_hit_o),
   .buf1_hit_o (buf1_hit_o)
);

// File: tb/sim_can_accept_steer.sv
`timescale 1ns/1ps
module sim_can_accept_steer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_mode_i = 1'b0, cfg_we_i = 1'b0;
   logic [3:0]  cfg_addr_i = '0;
   logic [29:0] cfg_wdata_i = '0;
   logic        frm_valid_i = 1'b0, frm_ide_i = 1'b0, frm_rtr_i = 1'b0;
   logic [28:0] frm_id_i = '0;
   logic [7:0]  frm_db0_i = '0, frm_db1_i = '0;
   logic [1:0]  clr_full_i = '0;
   logic [1:0]  store_o, full_o;
   logic        ovf_o;
   logic [28:0] buf0_id_o, buf1_id_o;
   logic [2:0]  buf0_hit_o, buf1_hit_o;

   always #2.5 clk = ~clk;

   can_accept_steer u0 (.*);

   int vectors = 0, miscompares = 0;
   bit done = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [28:0] m_filt [6];
   bit          m_fext [6];
   logic [28:0] m_mask [2];
   bit   [1:0]  m_mode [2];
   bit          m_roll;
   bit   [1:0]  m_full, m_store;
   bit          m_ovf;
   logic [28:0] m_id [2];
   bit   [2:0]  m_hit [2];

   function automatic bit fmatch(input int f);
      bit ok;
      int ms;
      ok = (m_fext[f] == frm_ide_i);
      ms = (f < 2) ? 0 : 1;
      for (int b = 0; b < 29; b++) begin
         bit used;
         logic kb;
         used = 1'b0;
         kb   = 1'b0;
         if (frm_ide_i || b >= 18) begin used = 1'b1; kb = frm_id_i[b]; end
         else if (b >= 10)         begin used = !frm_rtr_i; kb = frm_db0_i[b-10]; end
         else if (b >= 2)          begin used = !frm_rtr_i; kb = frm_db1_i[b-2]; end
         if (used && m_mask[ms][b] && kb !== m_filt[f][b]) ok = 1'b0;
      end
      return ok;
   endfunction

   function automatic bit admits(input bit [1:0] md, input bit any);
      if (md == 2'd3) return 1'b1;
      if (md == 2'd2) return any && frm_ide_i;
      if (md == 2'd1) return any && !frm_ide_i;
      return any;
   endfunction

   always @(posedge clk or negedge rst_n) begin : model
      int  i0, i1;
      bit  a0, a1, rp;
      bit  [1:0] st;
      if (!rst_n) begin
         for (int f = 0; f < 6; f++) begin m_filt[f] = '0; m_fext[f] = 0; end
         for (int s = 0; s < 2; s++) begin m_mask[s] = '0; m_mode[s] = 0; m_id[s] = '0; m_hit[s] = 0; end
         m_roll = 0; m_full = 0; m_store = 0; m_ovf = 0;
      end else begin
         st = 0; m_ovf = 0;
         if (frm_valid_i && !cfg_mode_i) begin
            i0 = 7; i1 = 7;
            for (int f = 1; f >= 0; f--) if (fmatch(f)) i0 = f;
            for (int f = 5; f >= 2; f--) if (fmatch(f)) i1 = f;
            a0 = admits(m_mode[0], i0 != 7);
            a1 = admits(m_mode[1], i1 != 7);
            if (m_mode[0] == 2'd3) i0 = 7;
            if (m_mode[1] == 2'd3) i1 = 7;
            rp = a0 && m_full[0] && m_roll;
            if (a0 && !m_full[0]) begin
               st[0] = 1; m_id[0] = frm_id_i; m_hit[0] = 3'(i0);
            end else if ((a1 || rp) && !m_full[1]) begin
               st[1] = 1; m_id[1] = frm_id_i; m_hit[1] = rp ? 3'(i0) : 3'(i1);
            end else if (a0 || a1) m_ovf = 1;
         end
         for (int s = 0; s < 2; s++) m_full[s] = (m_full[s] && !clr_full_i[s]) || st[s];
         m_store = st;
         if (cfg_mode_i && cfg_we_i) begin
            if (cfg_addr_i < 6) begin
               m_filt[cfg_addr_i] = cfg_wdata_i[28:0];
               m_fext[cfg_addr_i] = cfg_wdata_i[29];
            end else if (cfg_addr_i < 8) m_mask[cfg_addr_i-6] = cfg_wdata_i[28:0];
            else if (cfg_addr_i == 8) begin m_mode[0] = cfg_wdata_i[1:0]; m_roll = cfg_wdata_i[2]; end
            else if (cfg_addr_i == 9) m_mode[1] = cfg_wdata_i[1:0];
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R6 store pulse vs model", store_o, m_store);
         chk("R6 overflow vs model", ovf_o, m_ovf);
         chk("R9 full flags vs model", full_o, m_full);
         chk("R2 slot0 id vs model", buf0_id_o, m_id[0]);
         chk("R2 slot1 id vs model", buf1_id_o, m_id[1]);
         chk("R7 slot0 hit vs model", buf0_hit_o, m_hit[0]);
         chk("R7 slot1 hit vs model", buf1_hit_o, m_hit[1]);
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [28:0] sid(input logic [10:0] s);
      return {s, 18'h0};
   endfunction

   task automatic cfg_wr(input logic [3:0] a, input logic [29:0] d);
      @(negedge clk);
      cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
      @(negedge clk);
      cfg_we_i = 0;
   endtask

   task automatic send(input bit ide, input bit rtr, input logic [28:0] id,
                       input logic [7:0] d0, input logic [7:0] d1);
      @(negedge clk);
      frm_valid_i = 1; frm_ide_i = ide; frm_rtr_i = rtr; frm_id_i = id;
      frm_db0_i = d0; frm_db1_i = d1;
      @(negedge clk);
      frm_valid_i = 0;
   endtask

   task automatic clear(input logic [1:0] c);
      @(negedge clk);
      clr_full_i = c;
      @(negedge clk);
      clr_full_i = 0;
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1;
         vectors++; miscompares++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk("R1 reset store", store_o, 0);
      chk("R1 reset overflow", ovf_o, 0);
      chk("R1 reset full", full_o, 0);
      chk("R1 reset ids", {buf0_id_o, buf1_id_o}, 0);
      chk("R1 reset hits", {buf0_hit_o, buf1_hit_o}, 0);
      rst_n = 1;

      // reset configuration: filter 0 and 2 take all standard frames
      send(1, 0, 29'h1555555, 8'h0, 8'h0);
      chk("R3 extended frame vs standard-only filters", {store_o, ovf_o}, 3'b000);
      send(0, 0, sid(11'h155), 8'h11, 8'h22);
      chk("R2 first frame to slot 0", store_o, 2'b01);
      chk("R7 slot0 hit filter 0", buf0_hit_o, 0);
      send(0, 0, sid(11'h2AA), 8'h33, 8'h44);
      chk("R2 slot0 full, slot1 takes it", store_o, 2'b10);
      chk("R7 slot1 hit filter 2", buf1_hit_o, 2);
      send(0, 0, sid(11'h0F0), 8'h0, 8'h0);
      chk("R6 overflow pulse", ovf_o, 1);
      chk("R6 slot0 id unchanged", buf0_id_o, sid(11'h155));
      repeat (4) @(negedge clk);
      chk("R9 full held", full_o, 2'b11);
      clear(2'b11);
      chk("R9 full cleared", full_o, 2'b00);

      // second configuration
      @(negedge clk); cfg_mode_i = 1;
      cfg_wr(4'd6, {1'b0, 29'h1FFFFFFF});
      cfg_wr(4'd0, {1'b0, 11'h123, 8'hAB, 8'hCD, 2'b00});
      cfg_wr(4'd1, {1'b1, 29'h0ABCDEF});
      cfg_wr(4'd7, {1'b0, 29'h1FFFFF00});
      cfg_wr(4'd2, {1'b1, 29'h1234500});
      cfg_wr(4'd3, {1'b1, 29'h0777700});
      cfg_wr(4'd4, {1'b1, 29'h07777FF});
      cfg_wr(4'd5, {1'b1, 29'h1FFFFFFF});
      @(negedge clk); cfg_mode_i = 0;

      send(0, 0, sid(11'h123), 8'hAB, 8'hCD);
      chk("R4 standard data bytes match", store_o, 2'b01);
      chk("R4 hit filter 0", buf0_hit_o, 0);
      clear(2'b01);
      send(0, 0, sid(11'h123), 8'hAB, 8'hCE);
      chk("R4 data byte 1 mismatch rejected", {store_o, ovf_o}, 3'b000);
      send(0, 1, sid(11'h123), 8'h00, 8'h00);
      chk("R4 remote frame ignores data", store_o, 2'b01);
      clear(2'b01);
      send(1, 0, 29'h0ABCDEF, 8'h0, 8'h0);
      chk("R3 extended filter 1", buf0_hit_o, 1);
      chk("R3 extended store slot 0", store_o, 2'b01);
      clear(2'b01);
      send(1, 0, 29'h0777742, 8'h0, 8'h0);
      chk("R7 lowest of filters 3,4", buf1_hit_o, 3);
      clear(2'b10);

      // modes
      @(negedge clk); cfg_mode_i = 1;
      cfg_wr(4'd8, 30'h2);
      @(negedge clk); cfg_mode_i = 0;
      send(0, 0, sid(11'h123), 8'hAB, 8'hCD);
      chk("R5 mode 10 rejects standard", {store_o, ovf_o}, 3'b000);
      @(negedge clk); cfg_mode_i = 1;
      cfg_wr(4'd9, 30'h3);
      @(negedge clk); cfg_mode_i = 0;
      send(0, 0, sid(11'h7FF), 8'h5A, 8'hA5);
      chk("R5 mode 11 accepts all", store_o, 2'b10);
      chk("R5 mode 11 hit code 7", buf1_hit_o, 7);
      clear(2'b10);
      @(negedge clk); cfg_mode_i = 1;
      cfg_wr(4'd8, 30'h4);
      cfg_wr(4'd9, 30'h0);
      @(negedge clk); cfg_mode_i = 0;

      // rollover
      send(0, 0, sid(11'h123), 8'hAB, 8'hCD);
      chk("R8 first to slot 0", store_o, 2'b01);
      send(0, 0, sid(11'h123), 8'hAB, 8'hCD);
      chk("R8 rolled to slot 1", store_o, 2'b10);
      chk("R8 slot1 records filter 0", buf1_hit_o, 0);
      send(1, 0, 29'h0ABCDEF, 8'h0, 8'h0);
      chk("R6 both full overflow", ovf_o, 1);
      chk("R6 slot1 id unchanged", buf1_id_o, sid(11'h123));
      clear(2'b01);
      chk("R9 only slot 0 cleared", full_o, 2'b10);
      clear(2'b10);

      // write gating and configuration-state frames
      cfg_wr(4'd6, 30'h0);
      send(0, 0, sid(11'h124), 8'hAB, 8'hCD);
      chk("R10 mask write outside config ignored", store_o, 2'b00);
      @(negedge clk); cfg_mode_i = 1;
      send(0, 0, sid(11'h123), 8'hAB, 8'hCD);
      chk("R10 frame in config state ignored", {store_o, ovf_o, full_o}, 5'b0);
      @(negedge clk); cfg_mode_i = 0;
      repeat (2) @(negedge clk);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule